// File: doc/BRIEF.md
# Multi-Mode Transmit Modulation Controller

This block turns a serial transmit bit stream into the control words that drive a low-power RF transmitter. For the fractional-N synthesizer it produces a signed frequency offset, in units of the comparison clock divided by 2^12. For the power DAC it produces a 7-bit output-level code and an amplifier enable. A configuration word picks one of four keying schemes. Each scheme gives the two 7-bit level fields and the 3-bit exponent its own meaning. The four schemes are binary frequency keying, stepped-ramp (Gaussian-style) frequency keying, two-level amplitude keying, and on-off keying.

The block runs on the comparison clock. It divides that clock by a prescale factor D and then by a step count K to form a transmit bit clock. External logic shifts data onto the serial input using this clock. The data bit is captured on the internal rising edge of the bit clock. Configuration writes go into a shadow copy and become active only at that same bit boundary, so the control words never glitch in the middle of a bit. In the ramped scheme, the offset advances toward its new target once per prescale period, which gives K steps per bit.

Top module: `tx_mod_ctrl`

## Requirements
- R1: A synchronous reset sets freq_ofs to 0, dac_code to 0 and pa_en to 0, and restarts the rate counters so that tx_clk is high. All three outputs stay at zero until the first bit boundary after reset.
- R2: The bit period is D*K clock cycles, with D = cfg_div (0 counts as 1) and K = cfg_idx (values below 2 count as 2). tx_clk is high for the first ceil(K/2)*D cycles of each period and low for the rest.
- R3: tx_data is captured at the clock edge on which tx_clk rises. The outputs for the new bit appear in that same cycle, and dac_code and pa_en then hold for the whole bit.
- R4: When cfg_mode = 2'b00 (frequency keying), freq_ofs is +M for a 1 bit and −M for a 0 bit, with M = cfg_lo, except that a value of 0 is replaced by 1. dac_code = cfg_hi and pa_en = 1.
- R5: When cfg_mode = 2'b01 (ramped keying), the target is +2^E for a 1 bit and −2^E for a 0 bit, with E = cfg_exp. Every D cycles freq_ofs moves toward the target by max(1, 2^E/4) and stops when it reaches the target. The offset is 0 while any other scheme is active. dac_code = cfg_hi and pa_en = 1.
- R6: When cfg_mode = 2'b10 (amplitude keying), dac_code is cfg_lo for a 0 bit and cfg_hi for a 1 bit. freq_ofs = 0 and pa_en = 1.
- R7: When cfg_mode = 2'b11 (on-off keying), a 1 bit gives dac_code = cfg_hi and pa_en = 1. A 0 bit gives dac_code = 0 and pa_en = 0. freq_ofs = 0 in both cases.
- R8: A configuration write (cfg_wr high for one cycle) changes no output and no timing until the next tx_clk rising edge. At that edge all written fields, including D and K, take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison (reference) clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe that loads all cfg_* fields into the shadow copy |
| cfg_mode | input | 2 | Scheme: 00 frequency, 01 ramped frequency, 10 amplitude, 11 on-off |
| cfg_lo | input | 7 | Deviation M (00), or low level (10) |
| cfg_hi | input | 7 | High output level |
| cfg_exp | input | 3 | Ramped-scheme deviation exponent E |
| cfg_div | input | DIV_W | Prescale factor D |
| cfg_idx | input | IDX_W | Steps per bit K |
| tx_data | input | 1 | Serial transmit data |
| tx_clk | output | 1 | Transmit bit clock |
| freq_ofs | output | OFS_W | Signed synthesizer offset in 1/2^12 units |
| dac_code | output | 7 | Power DAC level code |
| pa_en | output | 1 | Output stage enable |

## Verification
A bit boundary is a clock edge. After that edge, tx_clk, dac_code and pa_en already show the new bit; no extra register sits in between. The ramped offset moves one step D cycles later and then again every D cycles. A configuration write lands in the shadow copy on the edge that samples cfg_wr, and the active fields change only at the next boundary edge. The bench keeps its own cycle-exact model of the bit-period count, the prescale phase and the ramp value. The model advances on the same edges as the design, and every output is compared on the falling edge that follows. Each comparison therefore falls in the first cycle in which a result is due.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

  localparam int LVL_W = 7;
  localparam int EXP_W = 3;

  typedef enum logic [1:0] {
    MOD_FSK  = 2'b00,
    MOD_GFSK = 2'b01,
    MOD_ASK  = 2'b10,
    MOD_OOK  = 2'b11
  } mod_e;

  typedef struct packed {
    mod_e             mode;
    logic [LVL_W-1:0] lo;
    logic [LVL_W-1:0] hi;
    logic [EXP_W-1:0] expo;
  } mod_cfg_t;

  // Frequency-keying magnitude: zero is not a legal deviation, raise it to 1.
  function automatic logic [LVL_W-1:0] fsk_mag(input logic [LVL_W-1:0] v);
    return (v == '0) ? LVL_W'(1) : v;
  endfunction

  // Ramped-scheme peak deviation 2^e.
  function automatic int ramp_peak(input logic [EXP_W-1:0] e);
    return 1 << e;
  endfunction

  // Ramp increment per prescale period: a quarter of the peak, at least 1.
  function automatic int ramp_step(input logic [EXP_W-1:0] e);
    int q;
    q = (1 << e) >> 2;
    return (q == 0) ? 1 : q;
  endfunction

endpackage

// File: rtl/tmc_rate_gen.sv
module tmc_rate_gen #(
  parameter int DIV_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic [IDX_W-1:0] idx_val,
  output logic             step_tick,
  output logic             bit_stb,
  output logic             tx_clk
);
  logic [DIV_W-1:0] div_eff;
  logic [IDX_W-1:0] idx_eff;
  logic [IDX_W:0]   half_steps;
  logic [DIV_W-1:0] pre_cnt;
  logic [IDX_W-1:0] stp_cnt;

  always_comb begin
    div_eff    = (div_val == '0) ? DIV_W'(1) : div_val;
    idx_eff    = (idx_val < IDX_W'(2)) ? IDX_W'(2) : idx_val;
    half_steps = ({1'b0, idx_eff} + (IDX_W+1)'(1)) >> 1;
    step_tick  = (pre_cnt == div_eff - DIV_W'(1));
    bit_stb    = step_tick && (stp_cnt == idx_eff - IDX_W'(1));
    tx_clk     = ({1'b0, stp_cnt} < half_steps);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      stp_cnt <= '0;
    end else if (step_tick) begin
      pre_cnt <= '0;
      stp_cnt <= bit_stb ? '0 : stp_cnt + IDX_W'(1);
    end else begin
      pre_cnt <= pre_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/tmc_gfsk_ramp.sv
module tmc_gfsk_ramp
  import tmc_pkg::*;
#(
  parameter int OFS_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    enable,
  input  logic                    bit_val,
  input  logic [EXP_W-1:0]        exp_sel,
  output logic signed [OFS_W-1:0] ofs
);
  logic signed [OFS_W-1:0] peak, step, tgt, up, dn;

  always_comb begin
    peak = OFS_W'(ramp_peak(exp_sel));
    step = OFS_W'(ramp_step(exp_sel));
    tgt  = bit_val ? peak : -peak;
    up   = ofs + step;
    dn   = ofs - step;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      ofs <= '0;
    end else if (tick) begin
      if (ofs < tgt)      ofs <= (up > tgt) ? tgt : up;
      else if (ofs > tgt) ofs <= (dn < tgt) ? tgt : dn;
    end
  end
endmodule

// File: rtl/tmc_level_map.sv
module tmc_level_map
  import tmc_pkg::*;
#(
  parameter int OFS_W = 9
) (
  input  logic                    live,
  input  logic                    bit_val,
  input  mod_cfg_t                cfg,
  input  logic signed [OFS_W-1:0] ramp_ofs,
  output logic signed [OFS_W-1:0] freq_ofs,
  output logic [LVL_W-1:0]        dac_code,
  output logic                    pa_en
);
  logic signed [OFS_W-1:0] fsk_s;

  always_comb begin
    fsk_s    = OFS_W'(fsk_mag(cfg.lo));
    freq_ofs = '0;
    dac_code = '0;
    pa_en    = 1'b0;
    if (live) begin
      unique case (cfg.mode)
        MOD_FSK: begin
          freq_ofs = bit_val ? fsk_s : -fsk_s;
          dac_code = cfg.hi;
          pa_en    = 1'b1;
        end
        MOD_GFSK: begin
          freq_ofs = ramp_ofs;
          dac_code = cfg.hi;
          pa_en    = 1'b1;
        end
        MOD_ASK: begin
          dac_code = bit_val ? cfg.hi : cfg.lo;
          pa_en    = 1'b1;
        end
        MOD_OOK: begin
          dac_code = bit_val ? cfg.hi : '0;
          pa_en    = bit_val;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tx_mod_ctrl.sv
module tx_mod_ctrl
  import tmc_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int IDX_W = 4,
  parameter int OFS_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [1:0]              cfg_mode,
  input  logic [LVL_W-1:0]        cfg_lo,
  input  logic [LVL_W-1:0]        cfg_hi,
  input  logic [EXP_W-1:0]        cfg_exp,
  input  logic [DIV_W-1:0]        cfg_div,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic                    tx_data,
  output logic                    tx_clk,
  output logic signed [OFS_W-1:0] freq_ofs,
  output logic [LVL_W-1:0]        dac_code,
  output logic                    pa_en
);
  mod_cfg_t         sh_cfg, act_cfg;
  logic [DIV_W-1:0] sh_div, act_div;
  logic [IDX_W-1:0] sh_idx, act_idx;
  logic             live, bit_q;

  // Named internal events, observed by the bound checker.
  logic                    step_tick;
  logic                    bit_stb;
  logic                    ramp_en;
  logic signed [OFS_W-1:0] ramp_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg  <= '0;
      sh_div  <= '0;
      sh_idx  <= '0;
      act_cfg <= '0;
      act_div <= '0;
      act_idx <= '0;
      live    <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        sh_cfg <= '{mode: mod_e'(cfg_mode), lo: cfg_lo, hi: cfg_hi, expo: cfg_exp};
        sh_div <= cfg_div;
        sh_idx <= cfg_idx;
      end
      if (bit_stb) begin
        act_cfg <= sh_cfg;
        act_div <= sh_div;
        act_idx <= sh_idx;
        live    <= 1'b1;
        bit_q   <= tx_data;
      end
    end
  end

  tmc_rate_gen #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_rate (
    .clk      (clk),
    .rst      (rst),
    .div_val  (act_div),
    .idx_val  (act_idx),
    .step_tick(step_tick),
    .bit_stb  (bit_stb),
    .tx_clk   (tx_clk)
  );

  assign ramp_en = live && (act_cfg.mode == MOD_GFSK);

  tmc_gfsk_ramp #(.OFS_W(OFS_W)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .tick   (step_tick),
    .enable (ramp_en),
    .bit_val(bit_q),
    .exp_sel(act_cfg.expo),
    .ofs    (ramp_ofs)
  );

  tmc_level_map #(.OFS_W(OFS_W)) u_map (
    .live    (live),
    .bit_val (bit_q),
    .cfg     (act_cfg),
    .ramp_ofs(ramp_ofs),
    .freq_ofs(freq_ofs),
    .dac_code(dac_code),
    .pa_en   (pa_en)
  );
endmodule

// File: rtl/tx_mod_ctrl_chk.sv
module tx_mod_ctrl_chk #(
  parameter int OFS_W = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bit_stb,
  input logic                    step_tick,
  input logic                    tx_clk,
  input logic signed [OFS_W-1:0] freq_ofs,
  input logic [6:0]              dac_code,
  input logic                    pa_en
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (freq_ofs == '0 && dac_code == '0 && !pa_en));

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> ($stable(dac_code) && $stable(pa_en)));

  // R5
  ofs_step_only_chk: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(freq_ofs));

  // R2
  clk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> $rose(tx_clk));

  // R7
  off_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !pa_en |-> (dac_code == '0 && freq_ofs == '0));
endmodule

bind tx_mod_ctrl tx_mod_ctrl_chk #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_stb  (bit_stb),
  .step_tick(step_tick),
  .tx_clk   (tx_clk),
  .freq_ofs (freq_ofs),
  .dac_code (dac_code),
  .pa_en    (pa_en)
);

// File: tb/tx_mod_ctrl_test.sv
module tx_mod_ctrl_test;
  localparam int DIV_W = 4;
  localparam int IDX_W = 4;
  localparam int OFS_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [6:0] cfg_lo = '0, cfg_hi = '0;
  logic [2:0] cfg_exp = '0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic tx_data = 1'b0;
  logic tx_clk;
  logic signed [OFS_W-1:0] freq_ofs;
  logic [6:0] dac_code;
  logic pa_en;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench model: shadow (m_*), active (a_*), phase counters, ramp value
  int m_mode, m_lo, m_hi, m_exp, m_div, m_idx;
  int a_mode, a_lo, a_hi, a_exp, a_div, a_idx;
  int live, bitm, cib, pc, gf;

  always #5 clk = ~clk;

  tx_mod_ctrl #(.DIV_W(DIV_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_exp(cfg_exp),
    .cfg_div(cfg_div), .cfg_idx(cfg_idx), .tx_data(tx_data),
    .tx_clk(tx_clk), .freq_ofs(freq_ofs), .dac_code(dac_code), .pa_en(pa_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int deff(); return (a_div == 0) ? 1 : a_div; endfunction
  function automatic int keff(); return (a_idx < 2) ? 2 : a_idx; endfunction

  task automatic model_clear();
    m_mode = 0; m_lo = 0; m_hi = 0; m_exp = 0; m_div = 0; m_idx = 0;
    a_mode = 0; a_lo = 0; a_hi = 0; a_exp = 0; a_div = 0; a_idx = 0;
    live = 0; bitm = 0; cib = 0; pc = 0; gf = 0;
  endtask

  task automatic compare();
    int e_ofs, e_dac, e_pa, mag, hi_t;
    string lab;
    e_ofs = 0; e_dac = 0; e_pa = 0; lab = "R1 idle";
    if (live != 0) begin
      case (a_mode)
        0: begin mag = (a_lo == 0) ? 1 : a_lo; e_ofs = bitm ? mag : -mag;
                 e_dac = a_hi; e_pa = 1; lab = "R4 fsk"; end
        1: begin e_ofs = gf; e_dac = a_hi; e_pa = 1; lab = "R5 ramp"; end
        2: begin e_dac = bitm ? a_hi : a_lo; e_pa = 1; lab = "R6 ask"; end
        default: begin e_dac = bitm ? a_hi : 0; e_pa = bitm; lab = "R7 ook"; end
      endcase
    end
    chk({lab, " ofs"}, int'(freq_ofs), e_ofs);
    chk({lab, " dac"}, int'(dac_code), e_dac);
    chk({lab, " pa"}, int'(pa_en), e_pa);
    hi_t = ((keff() + 1) / 2) * deff();
    chk("R2 tx_clk level", int'(tx_clk), (cib < hi_t) ? 1 : 0);
  endtask

  // One clock edge: model advances on the same edge, checks on the falling edge.
  task automatic cyc();
    int p_wr, p_mode, p_lo, p_hi, p_exp, p_div, p_idx, p_data;
    int d, k, pk, st, tg;
    bit bstb, tick;
    p_wr = cfg_wr; p_mode = cfg_mode; p_lo = cfg_lo; p_hi = cfg_hi;
    p_exp = cfg_exp; p_div = cfg_div; p_idx = cfg_idx; p_data = tx_data;
    d = deff(); k = keff();
    bstb = (cib == d * k - 1);
    tick = (pc == d - 1);
    @(negedge clk);
    if (!(live != 0 && a_mode == 1)) gf = 0;
    else if (tick) begin
      pk = 1 << a_exp;
      st = ((pk >> 2) == 0) ? 1 : (pk >> 2);
      tg = (bitm != 0) ? pk : -pk;
      if (gf < tg) gf = (gf + st > tg) ? tg : gf + st;
      else if (gf > tg) gf = (gf - st < tg) ? tg : gf - st;
    end
    if (bstb) begin
      a_mode = m_mode; a_lo = m_lo; a_hi = m_hi; a_exp = m_exp;
      a_div = m_div; a_idx = m_idx; live = 1; bitm = p_data; cib = 0; pc = 0;
    end else begin
      cib++;
      pc = tick ? 0 : pc + 1;
    end
    if (p_wr != 0) begin
      m_mode = p_mode; m_lo = p_lo; m_hi = p_hi; m_exp = p_exp;
      m_div = p_div; m_idx = p_idx;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_data = lfsr[0];
    compare();
    // R3: the bit captured at the rising tx_clk edge shows at once on pa_en (on-off)
    if (bstb && a_mode == 3) chk("R3 captured bit", int'(pa_en), p_data);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic setcfg(input int md, input int lo, input int hi, input int ex,
                        input int dv, input int ix);
    cfg_mode = md[1:0]; cfg_lo = lo[6:0]; cfg_hi = hi[6:0]; cfg_exp = ex[2:0];
    cfg_div = dv[DIV_W-1:0]; cfg_idx = ix[IDX_W-1:0]; cfg_wr = 1'b1;
    cyc();
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    // R1: outputs cleared, counters restarted
    chk("R1 reset ofs", int'(freq_ofs), 0);
    chk("R1 reset dac", int'(dac_code), 0);
    chk("R1 reset pa", int'(pa_en), 0);
    chk("R1 reset tx_clk", int'(tx_clk), 1);
  endtask

  initial begin
    int held;
    do_reset();
    // R4: frequency keying, zero deviation raised to 1, several rate settings
    setcfg(0, 0, 33, 0, 1, 2);   run(40);
    setcfg(0, 127, 5, 0, 3, 4);  run(80);
    setcfg(0, 37, 64, 0, 0, 0);  run(40);
    // R5: ramped keying, sweep of every exponent
    for (int e = 0; e < 8; e++) begin
      setcfg(1, 0, 50, e, 2, 8); run(120);
    end
    setcfg(1, 0, 9, 7, 1, 3);    run(60);
    // R6 and R7
    setcfg(2, 10, 100, 0, 2, 3); run(60);
    setcfg(3, 0, 77, 0, 1, 5);   run(80);
    // R8: mid-bit write has no effect before the next boundary
    setcfg(2, 10, 100, 0, 4, 4); run(40);
    while (cib != 2) cyc();
    held = dac_code;
    setcfg(3, 20, 90, 0, 1, 2);
    chk("R8 write deferred dac", int'(dac_code), held);
    chk("R8 write deferred tx_clk", int'(tx_clk), 1);
    run(40);
    // R1: reset while running
    do_reset();
    run(6);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule